// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a small binary up-counter, four bits wide by default. All of its state changes happen on the rising clock edge. On an edge it can do one of four things: clear to zero, take a parallel preset value, advance by one, or hold. Both control strobes are active-low and synchronous. A control input that changes between edges has no effect until the next rising edge.

There are two count enables. Counting needs both of them high. Only the chain enable also gates the terminal-count carry, and that carry is combinational. To build a wider counter, feed each stage's carry into the chain enable of the next stage, share the clock and the local count enable, and every stage steps in the same cycle. To get a shorter count length, decode the terminal value you want from the outputs and feed it back into the clear strobe.

Top module: `sync_preset_counter`

## Requirements
- R1: The count changes only at a rising clock edge. Changing any control or data input between edges leaves `count` unchanged until the next edge.
- R2: When `clear_n` is low at a rising edge, `count` becomes 0 at that edge. This holds whatever the values of `load_n`, `din`, `cnt_en` and `chain_en`, so clear has the highest priority.
- R3: When `clear_n` is high and `load_n` is low at a rising edge, `count` takes the value of `din`. Bit 0 of `din` is the LSB. Any value from 0 to 2^WIDTH-1 can be loaded. Load overrides the count enables.
- R4: When `clear_n` and `load_n` are high and both `cnt_en` and `chain_en` are high, `count` increases by one at each rising edge. It wraps from all-ones to 0.
- R5: When `clear_n` and `load_n` are high and either `cnt_en` or `chain_en` is low, `count` keeps its value across the edge.
- R6: `carry_out` is high exactly when `chain_en` is high and `count` is all ones. It follows `chain_en` without waiting for a clock edge. `cnt_en` has no effect on it.
- R7: Two stages chained carry-to-chain-enable form an 8-bit counter. It counts every value up to 255 and then wraps to 0.
- R8: Decode a count of 9 and drive `clear_n` low with it. The counter then repeats 0 to 9 and never shows a value above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel preset, active low |
| cnt_en | input | 1 | Local count enable |
| chain_en | input | 1 | Chain count enable; also gates `carry_out` |
| din | input | WIDTH | Preset value, bit 0 is LSB |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count carry for cascading |

## Verification
Two pairs of functions can meet in one edge: clear with load, and load with counting. The bench raises `clear_n` low while `load_n` is low, a nonzero `din` is applied and both enables are high. It then expects zero. It also applies a load while both enables are high and expects the loaded value, not that value plus one. The cascade and modulo-10 scenarios use a carry or a decoded clear that arrives in the same cycle as an increment. Their expected sequences are computed in the bench from the count index.

// File: rtl/sync_preset_counter.sv
module sync_preset_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             chain_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] TERMINAL = '1;
  localparam logic [WIDTH-1:0] STEP     = WIDTH'(1);

  logic [WIDTH-1:0] q;

  always_ff @(posedge clk) begin
    if (!clear_n)              q <= '0;
    else if (!load_n)          q <= din;
    else if (cnt_en && chain_en) q <= q + STEP;
  end

  assign count     = q;
  assign carry_out = chain_en && (q == TERMINAL);

  logic chk_armed = 1'b0;
  always_ff @(posedge clk)
    if (!clear_n) chk_armed <= 1'b1;

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!chk_armed)
    !clear_n |=> count == '0);

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!chk_armed)
    clear_n && !load_n |=> count == $past(din));

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!chk_armed)
    clear_n && load_n && cnt_en && chain_en |=> count == $past(count) + STEP);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!chk_armed)
    clear_n && load_n && !(cnt_en && chain_en) |=> $stable(count));

  // R6
  carry_terminal_chk: assert property (@(posedge clk) disable iff (!chk_armed)
    carry_out |-> (count == TERMINAL) && chain_en);
endmodule

// File: tb/sync_preset_counter_tb.sv
module sync_preset_counter_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic       clear_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
  logic [3:0] din = 4'h0;
  logic [3:0] count;
  logic       carry_out;

  sync_preset_counter #(.WIDTH(4)) dut_i (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .din(din), .count(count), .carry_out(carry_out));

  logic       ch_clr_n = 1'b1, ch_en = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_co, hi_co;
  sync_preset_counter #(.WIDTH(4)) lo_i (
    .clk(clk), .clear_n(ch_clr_n), .load_n(1'b1), .cnt_en(ch_en),
    .chain_en(1'b1), .din(4'h0), .count(lo_q), .carry_out(lo_co));
  sync_preset_counter #(.WIDTH(4)) hi_i (
    .clk(clk), .clear_n(ch_clr_n), .load_n(1'b1), .cnt_en(ch_en),
    .chain_en(lo_co), .din(4'h0), .count(hi_q), .carry_out(hi_co));

  logic       mod_init_n = 1'b1, mod_run = 1'b0;
  logic [3:0] mod_q;
  logic       mod_co;
  logic       mod_clr_n;
  assign mod_clr_n = mod_init_n && (mod_q != 4'd9);
  sync_preset_counter #(.WIDTH(4)) mod_i (
    .clk(clk), .clear_n(mod_clr_n), .load_n(1'b1), .cnt_en(mod_run),
    .chain_en(1'b1), .din(4'h0), .count(mod_q), .carry_out(mod_co));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic c, input logic l, input logic e1,
                       input logic e2, input logic [3:0] d);
    @(negedge clk);
    clear_n = c; load_n = l; cnt_en = e1; chain_en = e2; din = d;
  endtask

  task automatic t_reset();
    drive(1'b0, 1'b1, 1'b0, 1'b0, 4'h0); edge_step();
    check("R2 reset clear", count, 0);
    check("R6 carry after clear", carry_out, 0);
  endtask

  task automatic t_clear_wins();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h7); edge_step();
    check("R3 load 7", count, 7);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 4'hC); edge_step();
    check("R2 clear beats load and count", count, 0);
  endtask

  task automatic t_load();
    for (int v = 0; v < 16; v += 5) begin
      drive(1'b1, 1'b0, 1'b1, 1'b1, v[3:0]); edge_step();
      check("R3 load over enables", count, v);
    end
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'hF); edge_step();
    check("R3 load 15", count, 15);
  endtask

  task automatic t_count();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'hB); edge_step();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
    for (int i = 1; i <= 20; i++) begin
      edge_step();
      check("R4 increment and wrap", count, (11 + i) % 16);
    end
  endtask

  task automatic t_hold();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h5); edge_step();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 4'h0); edge_step(); edge_step();
    check("R5 hold cnt_en low", count, 5);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h0); edge_step(); edge_step();
    check("R5 hold chain_en low", count, 5);
  endtask

  task automatic t_between_edges();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h3); edge_step();
    #1 clear_n = 1'b0; load_n = 1'b0; din = 4'hE; cnt_en = 1'b1; chain_en = 1'b1;
    #1 check("R1 no change before edge", count, 3);
    clear_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0;
    #1 check("R1 still no change", count, 3);
  endtask

  task automatic t_carry();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'hF); edge_step();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 4'h0); #1;
    check("R6 carry high at 15", carry_out, 1);
    chain_en = 1'b0; #1;
    check("R6 carry follows chain_en low", carry_out, 0);
    chain_en = 1'b1; cnt_en = 1'b1; #1;
    check("R6 cnt_en no effect on carry", carry_out, 1);
    cnt_en = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 1'b1, 4'hE); edge_step();
    check("R6 carry low at 14", carry_out, 0);
  endtask

  task automatic t_chain();
    @(negedge clk); ch_clr_n = 1'b0; ch_en = 1'b0;
    edge_step();
    check("R7 chain cleared", {hi_q, lo_q}, 0);
    @(negedge clk); ch_clr_n = 1'b1; ch_en = 1'b1;
    for (int i = 1; i <= 300; i++) begin
      edge_step();
      check("R7 8-bit chain value", {hi_q, lo_q}, i % 256);
      if (i == 255) check("R7 top carry at 255", hi_co, 1);
    end
    @(negedge clk); ch_en = 1'b0;
  endtask

  task automatic t_modulo();
    @(negedge clk); mod_init_n = 1'b0; mod_run = 1'b0;
    edge_step();
    check("R8 modulo init", mod_q, 0);
    @(negedge clk); mod_init_n = 1'b1; mod_run = 1'b1;
    for (int i = 1; i <= 35; i++) begin
      edge_step();
      check("R8 decade sequence", mod_q, i % 10);
    end
    @(negedge clk); mod_run = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_clear_wins();
    t_load();
    t_count();
    t_hold();
    t_between_edges();
    t_carry();
    t_chain();
    t_modulo();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule